// File: doc/BRIEF.md
# Parallel Port FIFO Service Interrupt Controller

This block decides when a parallel port with a byte FIFO asks the host for service. It compares the FIFO fill level against a programmed threshold and watches the DMA terminal-count strobe. It also watches the peripheral fault and acknowledge pins and the port's control bits. From these it produces one interrupt request on a shared, wired line. The line is pulled low for a fixed number of clocks and then released, so other sources can use it. The block also gates the DMA request coming from the transfer logic, and it holds everything quiet until software enables the FIFO path.

A threshold interrupt fires once when the FIFO moves from below the threshold to at or above it. In the host-to-peripheral direction the quantity compared is the number of free bytes. In the peripheral-to-host direction it is the number of stored bytes. Clearing the service mask re-checks the condition, so a level that was reached while masked still produces an interrupt. The fault and acknowledge pins are asynchronous and are synchronised before their edges are detected. An event that arrives while a pulse is in progress is kept and produces one more pulse.

Top module: `ppfifo_svc_irq`

## Requirements
- R1: During reset and right after it, `irq_pull_low` is 0 and `dma_req_out` is 0.
- R2: While `fifo_mode_en` is 0, no interrupt pulse is produced and `dma_req_out` stays 0.
- R3: While `svc_mask` is 1, `dma_req_out` is 0, and neither threshold nor terminal-count events produce a pulse. `dma_req_out` equals `dma_req_in` only when `fifo_mode_en`=1, `dma_en`=1 and `svc_mask`=0.
- R4: With `svc_mask`=0 and `dma_en`=1, a one-cycle `dma_tc` high starts a pulse on the next clock edge.
- R5: With `dir_rd`=0 and `dma_en`=0, exactly one pulse fires when the free count (16 - `fill_lvl`) first reaches at least `thr_code`+1. The pulse does not repeat while the condition stays true.
- R6: With `dir_rd`=1 and `dma_en`=0, exactly one pulse fires when `fill_lvl` first reaches at least `thr_code`+1.
- R7: If the threshold condition already holds when `svc_mask` goes from 1 to 0, a pulse fires without any further change of fill level.
- R8: With `flt_irq_off`=0, a high-to-low transition of `fault_n` produces a pulse. Changing `flt_irq_off` from 1 to 0 while `fault_n` is low also produces one. With `flt_irq_off`=1, a falling `fault_n` produces none.
- R9: With `ack_irq_en`=1, a low-to-high transition of `ack_n` produces a pulse. A falling edge, or any edge while `ack_irq_en`=0, produces none.
- R10: Each pulse holds `irq_pull_low` high for exactly 4 cycles. Events in the same idle cycle merge into one pulse. An event during a pulse gives exactly one more pulse, which follows a single idle cycle.
- R11: While `dma_en`=1, crossings of the fill threshold produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode_en | input | 1 | FIFO or extended mode selected; 0 keeps the block idle |
| svc_mask | input | 1 | Service mask: 1 blocks DMA requests and service interrupts |
| dma_en | input | 1 | 1 = DMA transfers, 0 = programmed I/O |
| dir_rd | input | 1 | 0 = host to peripheral, 1 = peripheral to host |
| flt_irq_off | input | 1 | Fault interrupt disable; 0 enables fault interrupts |
| ack_irq_en | input | 1 | Acknowledge rising-edge interrupt enable |
| fault_n | input | 1 | Asynchronous peripheral fault pin, active low |
| ack_n | input | 1 | Asynchronous peripheral acknowledge pin |
| dma_tc | input | 1 | DMA terminal-count strobe |
| fill_lvl | input | 5 | Bytes currently held in the FIFO, 0 to 16 |
| thr_code | input | 4 | Threshold minus one |
| dma_req_in | input | 1 | Raw DMA request from the transfer logic |
| dma_req_out | output | 1 | Gated DMA request |
| irq_pull_low | output | 1 | 1 = drive the shared interrupt line low; 0 = release it |

## Verification
The terminal-count strobe and a synchronised acknowledge rising edge can reach the pulse generator in the same clock. The bench provokes this by raising `ack_n` and then strobing `dma_tc` two cycles later, which is exactly the synchroniser latency. It accepts only a single 4-cycle pulse as the result. A second collision, an event landing inside a running pulse, is judged against the full cycle pattern: 4 high, 1 low, 4 high, 1 low.

// File: rtl/ppsi_pkg.sv
package ppsi_pkg;

   // control bits that steer event qualification
   typedef struct packed {
      logic mode_en;
      logic mask;
      logic dma_en;
      logic dir_rd;
      logic flt_off;
      logic ack_en;
   } ppsi_ctl_t;

   // interrupt sources, used as bit indices of the event vector
   typedef enum logic [1:0] {
      SRC_THR = 2'd0,
      SRC_TC  = 2'd1,
      SRC_FLT = 2'd2,
      SRC_ACK = 2'd3
   } ppsi_src_e;

   localparam int unsigned PPSI_NUM_SRC = 4;

endpackage

// File: rtl/ppsi_sync.sv
module ppsi_sync #(
   parameter int unsigned W       = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ppsi_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ppsi_event.sv
module ppsi_event import ppsi_pkg::*; #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LVL_W = 5,
   parameter int unsigned THR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  ppsi_ctl_t               ctl,
   input  logic [LVL_W-1:0]        fill,
   input  logic [THR_W-1:0]        thr_code,
   input  logic                    dma_tc,
   input  logic                    fault_s,
   input  logic                    ack_s,
   output logic [PPSI_NUM_SRC-1:0] ev
);

   logic [LVL_W-1:0] thr_val;
   logic [LVL_W-1:0] free_cnt;
   logic             lvl_ok;
   logic             cond;
   logic             cond_q, mask_q, flt_q, ack_q, off_q;

   assign thr_val  = LVL_W'(thr_code) + LVL_W'(1);
   assign free_cnt = LVL_W'(DEPTH) - fill;
   assign lvl_ok   = ctl.dir_rd ? (fill >= thr_val) : (free_cnt >= thr_val);
   assign cond     = ctl.mode_en & ~ctl.dma_en & lvl_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         mask_q <= 1'b1;
         flt_q  <= 1'b1;
         ack_q  <= 1'b1;
         off_q  <= 1'b1;
      end else begin
         cond_q <= cond;
         mask_q <= ctl.mask;
         flt_q  <= fault_s;
         ack_q  <= ack_s;
         off_q  <= ctl.flt_off;
      end
   end

   // threshold: new crossing, or condition found true on unmask
   assign ev[SRC_THR] = ctl.mode_en & ~ctl.mask & cond & (~cond_q | mask_q);
   assign ev[SRC_TC]  = ctl.mode_en & ~ctl.mask & ctl.dma_en & dma_tc;
   assign ev[SRC_FLT] = ctl.mode_en & ~ctl.flt_off & ~fault_s & (flt_q | off_q);
   assign ev[SRC_ACK] = ctl.mode_en & ctl.ack_en & ack_s & ~ack_q;

   AST_THR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      ev[SRC_THR] |=> !ev[SRC_THR]);                                     // R5
   AST_UNMASK_RECHECK: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl.mask) && cond) |-> ev[SRC_THR]);                        // R7
   AST_DMA_NO_THR: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.dma_en |-> !ev[SRC_THR]);                                      // R11

endmodule

// File: rtl/ppsi_pulse.sv
module ppsi_pulse #(
   parameter int unsigned PULSE_CYC = 4,
   parameter int unsigned N_SRC     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] ev,
   output logic             drv,
   output logic             pend
);

   localparam int unsigned CW = $clog2(PULSE_CYC + 1);

   logic          any_ev;
   logic [CW-1:0] cnt;
   logic [CW:0]   run_q;

   assign any_ev = |ev;
   assign drv    = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else if (cnt == '0) begin
         if (any_ev || pend) begin
            cnt  <= CW'(PULSE_CYC);
            pend <= 1'b0;
         end
      end else begin
         cnt <= cnt - CW'(1);
         if (any_ev) pend <= 1'b1;
      end
   end

   // length of the current low pulse, for the width check
   always_ff @(posedge clk) begin
      if (!rst_n)   run_q <= '0;
      else if (drv) run_q <= run_q + (CW+1)'(1);
      else          run_q <= '0;
   end

   AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv) |-> (run_q == (CW+1)'(PULSE_CYC)));                     // R10
   AST_EV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      any_ev |=> (drv || pend));                                         // R10
   AST_PEND_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !drv) |=> (drv && !pend));                                // R10

endmodule

// File: rtl/ppfifo_svc_irq.sv
module ppfifo_svc_irq import ppsi_pkg::*; #(
   parameter  int unsigned FIFO_DEPTH  = 16,
   parameter  int unsigned PULSE_CYC   = 4,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned LVL_W       = $clog2(FIFO_DEPTH + 1),
   localparam int unsigned THR_W       = $clog2(FIFO_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_mode_en,
   input  logic             svc_mask,
   input  logic             dma_en,
   input  logic             dir_rd,
   input  logic             flt_irq_off,
   input  logic             ack_irq_en,
   input  logic             fault_n,
   input  logic             ack_n,
   input  logic             dma_tc,
   input  logic [LVL_W-1:0] fill_lvl,
   input  logic [THR_W-1:0] thr_code,
   input  logic             dma_req_in,
   output logic             dma_req_out,
   output logic             irq_pull_low
);

   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ppfifo_svc_irq: FIFO_DEPTH must be a power of two, at least 2");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("ppfifo_svc_irq: PULSE_CYC must be at least 1");
      end
   endgenerate

   ppsi_ctl_t                 ctl;
   logic [1:0]                pin_s;
   logic [PPSI_NUM_SRC-1:0]   ev;
   logic                      pend;

   assign ctl = '{mode_en: fifo_mode_en, mask: svc_mask, dma_en: dma_en,
                  dir_rd: dir_rd, flt_off: flt_irq_off, ack_en: ack_irq_en};

   ppsi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({fault_n, ack_n}),
      .q     (pin_s)
   );

   ppsi_event #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) u_event (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .fill     (fill_lvl),
      .thr_code (thr_code),
      .dma_tc   (dma_tc),
      .fault_s  (pin_s[1]),
      .ack_s    (pin_s[0]),
      .ev       (ev)
   );

   ppsi_pulse #(.PULSE_CYC(PULSE_CYC), .N_SRC(PPSI_NUM_SRC)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .drv   (irq_pull_low),
      .pend  (pend)
   );

   assign dma_req_out = dma_req_in & fifo_mode_en & dma_en & ~svc_mask;

   AST_MASK_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      svc_mask |-> !dma_req_out);                                        // R3
   AST_IDLE_NO_EV: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_mode_en |-> (ev == '0));                                     // R2
   AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_lvl <= LVL_W'(FIFO_DEPTH));                                   // R5
   AST_TC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode_en && !svc_mask && dma_en && dma_tc) |=> (irq_pull_low || pend)); // R4

endmodule

// File: tb/sim_ppfifo_svc_irq.sv
module sim_ppfifo_svc_irq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode_en = 1'b0, svc_mask = 1'b1, dma_en = 1'b0, dir_rd = 1'b0;
   logic       flt_irq_off = 1'b1, ack_irq_en = 1'b0;
   logic       fault_n = 1'b1, ack_n = 1'b1, dma_tc = 1'b0, dma_req_in = 1'b0;
   logic [4:0] fill_lvl = 5'd0;
   logic [3:0] thr_code = 4'd0;
   logic       dma_req_out, irq_pull_low;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ppfifo_svc_irq u0 (
      .clk(clk), .rst_n(rst_n), .fifo_mode_en(fifo_mode_en), .svc_mask(svc_mask),
      .dma_en(dma_en), .dir_rd(dir_rd), .flt_irq_off(flt_irq_off), .ack_irq_en(ack_irq_en),
      .fault_n(fault_n), .ack_n(ack_n), .dma_tc(dma_tc), .fill_lvl(fill_lvl),
      .thr_code(thr_code), .dma_req_in(dma_req_in), .dma_req_out(dma_req_out),
      .irq_pull_low(irq_pull_low)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_hi(input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (irq_pull_low) hi++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hi;
      int s;
      int pat;
      dma_req_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 irq in reset", int'(irq_pull_low), 0);
      chk("R1 dma in reset", int'(dma_req_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", int'(irq_pull_low), 0);

      // R2: path disabled
      svc_mask = 1'b0; dma_en = 1'b1;
      #1 chk("R2 dma gated when disabled", int'(dma_req_out), 0);
      dma_tc = 1'b1;
      @(negedge clk);
      dma_tc = 1'b0;
      count_hi(6, hi);
      chk("R2 no pulse when disabled", hi, 0);
      dma_req_in = 1'b0; dma_en = 1'b0; svc_mask = 1'b1;
      fifo_mode_en = 1'b1;
      count_hi(3, hi);

      // R5 / R6: threshold sweep over every code, both directions
      for (int d = 0; d < 2; d++) begin
         for (int t = 0; t < 16; t++) begin
            svc_mask = 1'b1;
            dir_rd   = d[0];
            thr_code = t[3:0];
            fill_lvl = (d == 1) ? 5'd0 : 5'd16;
            count_hi(3, hi);
            chk("R3 masked settle", hi, 0);
            svc_mask = 1'b0;
            count_hi(7, hi);
            chk(d ? "R6 below threshold" : "R5 below threshold", hi, 0);
            for (int k = 1; k <= 16; k++) begin
               fill_lvl = (d == 1) ? 5'(k) : 5'(16 - k);
               count_hi(7, hi);
               chk(d ? "R6 crossing pulse R10" : "R5 crossing pulse R10",
                   hi, (k == t + 1) ? 4 : 0);
            end
         end
      end

      // R7: threshold reached while masked, then unmask
      svc_mask = 1'b1; dir_rd = 1'b1; thr_code = 4'd3; fill_lvl = 5'd0;
      count_hi(3, hi);
      fill_lvl = 5'd8;
      count_hi(7, hi);
      chk("R3 masked crossing silent", hi, 0);
      svc_mask = 1'b0;
      count_hi(7, hi);
      chk("R7 unmask recheck", hi, 4);
      count_hi(7, hi);
      chk("R5 no repeat while held", hi, 0);
      svc_mask = 1'b1; fill_lvl = 5'd0;
      count_hi(3, hi);

      // R3: dma request gating
      dma_req_in = 1'b1; dma_en = 1'b1;
      #1 chk("R3 dma blocked by mask", int'(dma_req_out), 0);
      svc_mask = 1'b0;
      #1 chk("R3 dma passes", int'(dma_req_out), 1);
      dma_req_in = 1'b0;
      #1 chk("R3 dma follows input", int'(dma_req_out), 0);

      // R4: terminal count
      @(negedge clk);
      dma_tc = 1'b1;
      @(negedge clk);
      s = int'(irq_pull_low);
      dma_tc = 1'b0;
      chk("R4 tc starts next edge", s, 1);
      count_hi(6, hi);
      chk("R4 tc pulse length", hi + s, 4);
      svc_mask = 1'b1;
      dma_tc = 1'b1;
      @(negedge clk);
      dma_tc = 1'b0;
      count_hi(6, hi);
      chk("R3 tc masked", hi, 0);

      // R11: threshold ignored in DMA mode
      svc_mask = 1'b0; dir_rd = 1'b1; thr_code = 4'd3; fill_lvl = 5'd0;
      count_hi(3, hi);
      fill_lvl = 5'd10;
      count_hi(7, hi);
      chk("R11 no threshold pulse under DMA", hi, 0);
      svc_mask = 1'b1; fill_lvl = 5'd0; dma_en = 1'b0;
      count_hi(3, hi);

      // R8: fault
      flt_irq_off = 1'b0;
      count_hi(4, hi);
      chk("R8 enable with fault high", hi, 0);
      fault_n = 1'b0;
      count_hi(8, hi);
      chk("R8 fault falling", hi, 4);
      fault_n = 1'b1;
      count_hi(8, hi);
      chk("R8 fault rising silent", hi, 0);
      flt_irq_off = 1'b1;
      count_hi(3, hi);
      fault_n = 1'b0;
      count_hi(8, hi);
      chk("R8 fault disabled", hi, 0);
      flt_irq_off = 1'b0;
      count_hi(8, hi);
      chk("R8 enable while fault low", hi, 4);
      flt_irq_off = 1'b1; fault_n = 1'b1;
      count_hi(6, hi);

      // R9: acknowledge
      ack_irq_en = 1'b1;
      count_hi(3, hi);
      ack_n = 1'b0;
      count_hi(8, hi);
      chk("R9 ack falling silent", hi, 0);
      ack_n = 1'b1;
      count_hi(8, hi);
      chk("R9 ack rising", hi, 4);
      ack_irq_en = 1'b0;
      ack_n = 1'b0;
      count_hi(6, hi);
      ack_n = 1'b1;
      count_hi(8, hi);
      chk("R9 ack disabled", hi, 0);

      // R10: event during a pulse -> one more pulse after one idle cycle
      svc_mask = 1'b0; dma_en = 1'b1;
      count_hi(3, hi);
      pat = 0;
      dma_tc = 1'b1;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         pat = (pat << 1) | int'(irq_pull_low);
         dma_tc = (i == 2);
      end
      chk("R10 pending pattern", pat, 10'b1111011110);

      // R10: acknowledge edge and terminal count in the same cycle
      ack_irq_en = 1'b1; ack_n = 1'b0;
      count_hi(6, hi);
      ack_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      dma_tc = 1'b1;
      @(negedge clk);
      s = int'(irq_pull_low);
      dma_tc = 1'b0;
      chk("R10 coincident start", s, 1);
      count_hi(9, hi);
      chk("R10 coincident single pulse", hi + s, 4);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule